// File: doc/BRIEF.md
# Indirect Product-Data Table Reader

This block sits between a controller's register-access engine and the ordinary register file. Alongside the register file it holds four product-data tables of 256 bytes each: table 0 describes the mainboard, table 1 the backplane, and tables 2 and 3 are spare. The host cannot address the tables directly. It sets a seek pointer by writing two offset registers and then reads a data register. Each table has its own pointer and its own fixed group of three registers.

Every host write is passed through to the register file unchanged. This includes writes to the offset registers and the data registers. A host read of any address other than a data register is also forwarded to the register file. A read of a data register is instead redirected to the table memory, at the position the pointer gives. The table memory and the register file are both synchronous single-cycle memories outside this block. The table memory is loaded before reset is released. Every read is answered exactly one cycle after it is issued.

Top module: `vpd_seek_reader`

## Requirements
- R1: After reset `rspValid` is 0 and all four seek pointers are zero, so the first data-register read of any table returns that table's byte 0.
- R2: A write of value V to a table's offset-high register sets that table's pointer to V*256, which clears its low byte.
- R3: A write of value V to a table's offset-low register bitwise-ORs V into the pointer and leaves the pointer's upper byte unchanged.
- R4: A read of a data register answers one cycle later with `rspValid`=1 and the byte at `tblAddr` = {table index in bits 9:8, pointer bits 7:0}, taken from `tblRdata`.
- R5: When the pointer is 256 or more, the data-register read returns 0xFF.
- R6: Reading a data register leaves every pointer unchanged.
- R7: The register groups (offset high, offset low, data) are 0x056/0x057/0x058 for table 0, 0x059/0x05A/0x05B for table 1, 0x05C/0x05D/0x05E for table 2 and 0x060/0x061/0x062 for table 3. Each pointer changes only through its own group. Address 0x05F is an ordinary register.
- R8: Every write drives `rfEn`=1, `rfWrite`=1, `rfAddr` and `rfWdata` in the same cycle, with the request's address and data. A write produces no response.
- R9: A read of any address other than a data register drives `rfEn`=1 and `rfWrite`=0 in the same cycle. One cycle later it answers with `rspValid`=1 and `rfRdata`.
- R10: A data-register read does not access the register file (`rfEn`=0) and asserts `tblRdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host register access this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 11 | Register address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | Read response valid (one cycle after a read) |
| rspData | output | 8 | Read response byte |
| rfEn | output | 1 | Register file access strobe |
| rfWrite | output | 1 | Register file write enable |
| rfAddr | output | 11 | Register file address |
| rfWdata | output | 8 | Register file write data |
| rfRdata | input | 8 | Register file read data, one cycle after `rfEn` |
| tblRdEn | output | 1 | Table memory read strobe |
| tblAddr | output | 10 | Table memory address {table, byte} |
| tblRdata | input | 8 | Table memory read data, one cycle after `tblRdEn` |

## Verification
The assertions assume one access per cycle. They also assume that both memories return data exactly one cycle after their strobe, and that no request arrives in the same cycle as reset. The stimulus keeps to these assumptions: it drives one request per clock from a single task, and it models both memories as registered arrays that update on the clock edge after their strobe. Random operations are weighted toward the twelve group addresses and their neighbours. Pointer values are mixed so that both in-range and out-of-range positions occur.

// File: rtl/vpd_seek_pkg.sv
package vpd_seek_pkg;
  localparam int NUM_TABLES = 4;
  localparam int TBL_IDX_W  = $clog2(NUM_TABLES);
  localparam int BYTE_W     = 8;
  localparam int TBL_OFF_W  = 8;
  localparam int TBL_AW     = TBL_IDX_W + TBL_OFF_W;

  // Control -> datapath strobes
  typedef struct packed {
    logic [NUM_TABLES-1:0] hiWr;
    logic [NUM_TABLES-1:0] loWr;
    logic [NUM_TABLES-1:0] dataRd;
    logic                  plainRd;
  } seekStrb_t;

  // Offset-high register of table t; low and data follow at +1, +2.
  // Table 3 skips one address after table 2.
  function automatic int groupBase(input int t);
    return 'h56 + 3 * t + ((t >= 3) ? 1 : 0);
  endfunction
endpackage

// File: rtl/vpd_seek_ctrl.sv
module vpd_seek_ctrl
  import vpd_seek_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BYTE_W-1:0] reqWdata,
  output seekStrb_t         strb,
  output logic              rfEn,
  output logic              rfWrite,
  output logic [ADDR_W-1:0] rfAddr,
  output logic [BYTE_W-1:0] rfWdata
);
  logic [NUM_TABLES-1:0] hiHit, loHit, dataHit;

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(groupBase(t));
    assign hiHit[t]   = (reqAddr == BASE);
    assign loHit[t]   = (reqAddr == BASE + ADDR_W'(1));
    assign dataHit[t] = (reqAddr == BASE + ADDR_W'(2));
  end

  always_comb begin
    strb.hiWr    = (reqValid && reqWrite) ? hiHit : '0;
    strb.loWr    = (reqValid && reqWrite) ? loHit : '0;
    strb.dataRd  = (reqValid && !reqWrite) ? dataHit : '0;
    strb.plainRd = reqValid && !reqWrite && (dataHit == '0);
  end

  assign rfEn    = reqValid && !(|strb.dataRd);
  assign rfWrite = reqWrite;
  assign rfAddr  = reqAddr;
  assign rfWdata = reqWdata;

  AST_ONE_GROUP_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.hiWr, strb.loWr, strb.dataRd, strb.plainRd})) else $error("AST_ONE_GROUP_HIT"); // R7
  AST_NO_RF_ON_REDIR: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.dataRd) |-> !rfEn) else $error("AST_NO_RF_ON_REDIR"); // R10
  AST_WRITE_FORWARDED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> (rfEn && rfWrite)) else $error("AST_WRITE_FORWARDED"); // R8
endmodule

// File: rtl/vpd_seek_dp.sv
module vpd_seek_dp
  import vpd_seek_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seekStrb_t         strb,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic [BYTE_W-1:0] rfRdata,
  input  logic [BYTE_W-1:0] tblRdata,
  output logic              tblRdEn,
  output logic [TBL_AW-1:0] tblAddr,
  output logic              rspValid,
  output logic [BYTE_W-1:0] rspData
);
  localparam int HI_W = PTR_W - TBL_OFF_W;

  logic [NUM_TABLES-1:0][PTR_W-1:0] ptrQ;
  logic [TBL_IDX_W-1:0]             selIdx;
  logic [PTR_W-1:0]                 selPtr;
  logic                             rspValidQ, redirQ, oorQ;

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)              ptrQ[t] <= '0;
      else if (strb.hiWr[t])  ptrQ[t] <= {wrByte, {(PTR_W-BYTE_W){1'b0}}};
      else if (strb.loWr[t])  ptrQ[t] <= ptrQ[t] | PTR_W'(wrByte);
    end

    AST_HI_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rstN)
      strb.hiWr[t] |=> (ptrQ[t][TBL_OFF_W-1:0] == '0)) else $error("AST_HI_CLEARS_LOW"); // R2
    AST_LO_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      strb.loWr[t] |=> (ptrQ[t][PTR_W-1:TBL_OFF_W] == $past(ptrQ[t][PTR_W-1:TBL_OFF_W]))) else $error("AST_LO_KEEPS_HIGH"); // R3
  end

  always_comb begin
    selIdx = '0;
    for (int t = 0; t < NUM_TABLES; t++)
      if (strb.dataRd[t]) selIdx = TBL_IDX_W'(t);
  end

  assign selPtr  = ptrQ[selIdx];
  assign tblRdEn = |strb.dataRd;
  assign tblAddr = {selIdx, selPtr[TBL_OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      redirQ    <= 1'b0;
      oorQ      <= 1'b0;
    end else begin
      rspValidQ <= strb.plainRd || tblRdEn;
      redirQ    <= tblRdEn;
      oorQ      <= selPtr[PTR_W-1:TBL_OFF_W] != HI_W'(0);
    end
  end

  assign rspValid = rspValidQ;
  assign rspData  = !redirQ ? rfRdata : (oorQ ? {BYTE_W{1'b1}} : tblRdata);

  AST_READ_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (tblRdEn && (strb.hiWr == '0) && (strb.loWr == '0)) |=> $stable(ptrQ)) else $error("AST_READ_NO_ADVANCE"); // R6
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.plainRd || tblRdEn) |=> rspValid) else $error("AST_RSP_AFTER_READ"); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.plainRd || tblRdEn) |=> !rspValid) else $error("AST_NO_SPURIOUS_RSP"); // R8
  AST_OOR_FF: assert property (@(posedge clk) disable iff (!rstN)
    (tblRdEn && selPtr >= PTR_W'(256)) |=> (rspData == 8'hFF)) else $error("AST_OOR_FF"); // R5
endmodule

// File: rtl/vpd_seek_reader.sv
module vpd_seek_reader
  import vpd_seek_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PTR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic              rfEn,
  output logic              rfWrite,
  output logic [ADDR_W-1:0] rfAddr,
  output logic [7:0]        rfWdata,
  input  logic [7:0]        rfRdata,
  output logic              tblRdEn,
  output logic [9:0]        tblAddr,
  input  logic [7:0]        tblRdata
);
  seekStrb_t strb;

  vpd_seek_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .strb(strb),
    .rfEn(rfEn), .rfWrite(rfWrite), .rfAddr(rfAddr), .rfWdata(rfWdata)
  );

  vpd_seek_dp #(.PTR_W(PTR_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .strb(strb), .wrByte(reqWdata),
    .rfRdata(rfRdata), .tblRdata(tblRdata),
    .tblRdEn(tblRdEn), .tblAddr(tblAddr),
    .rspValid(rspValid), .rspData(rspData)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !rspValid) else $error("AST_RESET_QUIET"); // R1
endmodule

// File: tb/vpd_seek_reader_tb_top.sv
module vpd_seek_reader_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [10:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rspValid, rfEn, rfWrite, tblRdEn;
  logic [7:0]  rspData, rfWdata, rfRdata, tblRdata;
  logic [10:0] rfAddr;
  logic [9:0]  tblAddr;

  always #4 clk = ~clk;

  vpd_seek_reader dut_i (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [7:0]  rfMem [2048];
  logic [7:0]  rfShadow [2048];
  logic [15:0] ptrModel [4];
  int          groupAt [4] = '{'h56, 'h59, 'h5C, 'h60};

  function automatic logic [7:0] tableByte(input logic [9:0] a);
    return 8'((a * 29) ^ (a >> 2) ^ 10'h15A);
  endfunction

  always @(posedge clk) begin
    if (tblRdEn) tblRdata <= tableByte(tblAddr);
    if (rfEn && rfWrite) rfMem[rfAddr] <= rfWdata;
    if (rfEn && !rfWrite) rfRdata <= rfMem[rfAddr];
  end

  // role: 0 plain, 1 high, 2 low, 3 data
  function automatic int roleOf(input logic [10:0] a, output int tbl);
    tbl = 0;
    for (int t = 0; t < 4; t++) begin
      if (int'(a) == groupAt[t])     begin tbl = t; return 1; end
      if (int'(a) == groupAt[t] + 1) begin tbl = t; return 2; end
      if (int'(a) == groupAt[t] + 2) begin tbl = t; return 3; end
    end
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic access(input logic wr, input logic [10:0] a, input logic [7:0] d, input string req);
    int tbl, role;
    logic [7:0] exp;
    role = roleOf(a, tbl);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    #1;
    if (wr) begin
      check({req, " R8 rfEn"}, rfEn, 1);
      check({req, " R8 rfWrite"}, rfWrite, 1);
      check({req, " R8 rfAddr"}, rfAddr, a);
      check({req, " R8 rfWdata"}, rfWdata, d);
      rfShadow[a] = d;
      if (role == 1) ptrModel[tbl] = {d, 8'h00};
      if (role == 2) ptrModel[tbl] = ptrModel[tbl] | {8'h00, d};
    end else if (role == 3) begin
      check({req, " R10 rfEn"}, rfEn, 0);
      check({req, " R10 tblRdEn"}, tblRdEn, 1);
      check({req, " R4 tblAddr"}, tblAddr, {2'(tbl), ptrModel[tbl][7:0]});
    end else begin
      check({req, " R9 rfEn"}, rfEn, 1);
      check({req, " R9 rfWrite"}, rfWrite, 0);
    end
    @(negedge clk);
    reqValid = 1'b0;
    if (wr) check({req, " R8 no response"}, rspValid, 0);
    else begin
      check({req, " R4/R9 rspValid"}, rspValid, 1);
      if (role == 3)
        exp = (ptrModel[tbl] >= 16'd256) ? 8'hFF : tableByte({2'(tbl), ptrModel[tbl][7:0]});
      else exp = rfShadow[a];
      check({req, role == 3 ? " R4/R5 data" : " R9 data"}, rspData, exp);
    end
  endtask

  task automatic readData(input int t, input string req);
    access(1'b0, 11'(groupAt[t] + 2), 8'h00, req);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      rfMem[i] = 8'(i * 7 + 3);
      rfShadow[i] = 8'(i * 7 + 3);
    end
    for (int t = 0; t < 4; t++) ptrModel[t] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 rspValid in reset", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rspValid after reset", rspValid, 0);
    for (int t = 0; t < 4; t++) readData(t, "R1 byte 0 after reset");

    // R2/R5: high write clears low byte, pointer 0x100 is out of range
    access(1, 11'h057, 8'h34, "R3 low");
    access(1, 11'h056, 8'h01, "R2 high");
    readData(0, "R5 ptr 0x100");
    access(1, 11'h057, 8'h05, "R3 low on high");
    readData(0, "R5 ptr 0x105");
    access(1, 11'h056, 8'h00, "R2 high zero");
    access(1, 11'h057, 8'h7F, "R3 low");
    readData(0, "R2 cleared ptr 0x7F");
    // R3: OR accumulates
    access(1, 11'h05A, 8'h0F, "R3 first");
    access(1, 11'h05A, 8'hF0, "R3 second");
    readData(1, "R3 OR gives 0xFF");
    // R6: repeated reads return same byte
    readData(1, "R6 repeat 1");
    readData(1, "R6 repeat 2");
    // R7: table 3 group and the gap address
    access(1, 11'h061, 8'hA5, "R7 table3 low");
    access(1, 11'h05F, 8'h3C, "R7 gap write");
    access(0, 11'h05F, 8'h00, "R7 gap is plain");
    readData(3, "R7 table3 ptr");
    readData(2, "R7 table2 untouched");
    readData(0, "R7 table0 untouched");
    // R8: triplet writes visible in register file
    access(0, 11'h061, 8'h00, "R8 low reg stored");
    access(0, 11'h05A, 8'h00, "R8 low reg stored");
    access(1, 11'h062, 8'h77, "R8 data reg write");
    access(0, 11'h063, 8'h00, "R9 plain after group");

    for (int n = 0; n < 3000; n++) begin
      int kind = $urandom_range(0, 9);
      int t = $urandom_range(0, 3);
      logic [7:0] v = 8'($urandom());
      if (kind < 2)      access(1, 11'(groupAt[t]), ($urandom_range(0, 3) == 0) ? v : 8'h00, "R2 rand high");
      else if (kind < 4) access(1, 11'(groupAt[t] + 1), v, "R3 rand low");
      else if (kind < 7) readData(t, "R4 rand data");
      else if (kind < 8) access(0, 11'($urandom_range('h50, 'h6F)), 8'h00, "R9 rand read");
      else if (kind < 9) access(1, 11'($urandom_range(0, 2047)), v, "R8 rand write");
      else               access(0, 11'($urandom_range(0, 2047)), 8'h00, "R9 rand far read");
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule